// File: doc/BRIEF.md
# Eight-Channel Click-Free Volume Attenuator

This block scales a time-multiplexed stream of 24-bit signed audio samples for eight channels. Each sample arrives with a channel index and a valid strobe. Each channel has an 8-bit attenuation code on a logarithmic law of 0.375 dB per code. Code 0 is unity gain and code 255 is silence.

A channel never jumps to a new gain. Each channel keeps a current code. On every sample of that channel, the current code moves one step toward its goal. The goal is the channel's attenuation code, or 255 while the channel is muted. Muting a channel therefore fades it out, and unmuting fades it back in.

A master mute fades every channel out, whatever the per-channel mute bits say. An output polarity control negates every result. One shared multiplier serves all channels, and the result appears one clock after the input.

Top module: `chan_vol_atten`

## Requirements
- R1: After reset, every channel's current code is 0, `out_valid` is 0, and `out_chan` and `out_sample` are 0.
- R2: The gain of code k (k < 255) is G(k) = floor(2^23 * 10^(-0.375*k/20) + 0.5). G(255) = 0. The output is floor((s*G + 2^22) / 2^23), where s is the input sample.
- R3: `out_valid` equals `in_valid` of the previous cycle. When `out_valid` is 1, `out_chan` repeats that cycle's input channel index.
- R4: On each valid sample of channel c, the current code of c moves by exactly one toward its goal, or stays put once it equals the goal. The codes of the other channels do not change.
- R5: While mute bit c is 1, the goal of channel c is 255. After the bit clears, the code ramps back down to the attenuation code.
- R6: While `master_mute` is 1, the goal of every channel is 255, even when its mute bit is 0.
- R7: With `invert` at 1, the output is the negated scaled sample. A result of +2^23 saturates to 8388607 (0x7FFFFF).
- R8: A sample is scaled with the channel's code after that sample's step is taken.
- R9: Channel index i (0 = 1L, 1 = 1R, 2 = 2L, 3 = 2R, 4 = 3L, 5 = 3R, 6 = 4L, 7 = 4R) takes its code from `atten_codes[8*i+7:8*i]` and its mute flag from `mute_bits[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 3 | Channel index of the input sample |
| in_sample | input | 24 | Signed input sample |
| atten_codes | input | 64 | Eight 8-bit attenuation codes, channel i in bits [8i+7:8i] |
| mute_bits | input | 8 | Per-channel mute flags |
| master_mute | input | 1 | Mutes all channels |
| invert | input | 1 | Negates every output sample |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 3 | Channel index of the output sample |
| out_sample | output | 24 | Signed scaled output sample |

## Verification
A table of mixed vectors drives the block with:
- positive, negative, zero and both full-scale samples;
- varied channels, codes and polarity.

These vectors separate rounding errors from sign errors. A single channel is then swept from code 0 up to 254 and on to 255, one code per sample, which checks every entry of the gain law. A mid-level sample is used so that neighbouring codes give distinct outputs.

Further patterns each target one feature:
- Ramps toward a goal interleaved with samples on another channel show that only the addressed channel steps.
- Mute, unmute and master-mute sequences show the fade direction and the override.
- A negative full-scale sample at unity gain with polarity inversion exposes the saturation corner.

// File: rtl/chan_vol_atten.sv
module chan_vol_atten #(
  parameter int  NCH     = 8,
  parameter int  DW      = 24,
  parameter int  CW      = 8,
  parameter int  FRAC    = 23,
  parameter real STEP_DB = 0.375,
  parameter int  IW      = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IW-1:0]        in_chan,
  input  logic signed [DW-1:0] in_sample,
  input  logic [NCH*CW-1:0]    atten_codes,
  input  logic [NCH-1:0]       mute_bits,
  input  logic                 master_mute,
  input  logic                 invert,
  output logic                 out_valid,
  output logic [IW-1:0]        out_chan,
  output logic signed [DW-1:0] out_sample
);
  localparam int MAXC = (1 << CW) - 1;
  localparam int PW   = DW + FRAC + 2;
  localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [FRAC:0] gain_rom [MAXC+1];
  for (genvar k = 0; k <= MAXC; k++) begin : g_rom
    if (k == MAXC) begin : g_off
      assign gain_rom[k] = '0;
    end else begin : g_on
      localparam real LIN = (2.0 ** FRAC) * (10.0 ** (-STEP_DB * k / 20.0));
      assign gain_rom[k] = (FRAC+1)'($rtoi(LIN + 0.5));
    end
  end

  logic [CW-1:0] cur [NCH];
  logic [CW-1:0] now_c, tgt_c, nxt_c;
  logic signed [PW-1:0] prod, prod_r;
  logic signed [DW-1:0] scaled, shaped;
  logic unused_bits;

  assign now_c  = cur[in_chan];
  assign tgt_c  = (master_mute || mute_bits[in_chan]) ? CW'(MAXC) : atten_codes[in_chan*CW +: CW];
  assign nxt_c  = (now_c < tgt_c) ? now_c + 1'b1 : (now_c > tgt_c) ? now_c - 1'b1 : now_c;
  assign prod   = in_sample * $signed({1'b0, gain_rom[nxt_c]});
  assign prod_r = prod + HALF;
  assign scaled = prod_r[FRAC +: DW];
  assign shaped = !invert ? scaled : (scaled == SMIN) ? SMAX : -scaled;
  assign unused_bits = ^{prod_r[FRAC-1:0], prod_r[PW-1:FRAC+DW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) cur[i] <= '0;
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cur[in_chan] <= nxt_c;
        out_chan     <= in_chan;
        out_sample   <= shaped;
      end
    end
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  a_r3_chan_echo: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_chan == $past(in_chan));

  a_r2_silent_top: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cur[out_chan] == CW'(MAXC)) |-> out_sample == '0);

  a_r6_master_fade: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && master_mute) |->
      (cur[out_chan] == CW'(MAXC) || cur[out_chan] > $past(cur[in_chan])));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      cur[c] == $past(cur[c]) || cur[c] == CW'($past(cur[c]) + 1'b1) ||
      cur[c] == CW'($past(cur[c]) - 1'b1));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid && in_chan == IW'(c)) |-> cur[c] == $past(cur[c]));
  end
endmodule

// File: tb/chan_vol_atten_bench.sv
module chan_vol_atten_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_chan = '0;
  logic signed [23:0] in_sample = '0;
  logic [63:0] atten_codes;
  logic [7:0] mute_bits;
  logic master_mute = 1'b0;
  logic invert = 1'b0;
  logic out_valid;
  logic [2:0] out_chan;
  logic signed [23:0] out_sample;

  logic [7:0] b_att [8];
  logic [7:0] b_mute = '0;
  int mcode [8];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) atten_codes[i*8 +: 8] = b_att[i];
    mute_bits = b_mute;
  end

  chan_vol_atten u_chan_vol_atten (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .atten_codes(atten_codes), .mute_bits(mute_bits),
    .master_mute(master_mute), .invert(invert), .out_valid(out_valid),
    .out_chan(out_chan), .out_sample(out_sample));

  // {chan[3], sample[24], atten[8], mute, master, invert}
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 24'h400000, 8'd0,   1'b0, 1'b0, 1'b0},
    {3'd1, 24'hC00000, 8'd0,   1'b0, 1'b0, 1'b0},
    {3'd2, 24'h7FFFFF, 8'd10,  1'b0, 1'b0, 1'b0},
    {3'd3, 24'h800000, 8'd3,   1'b0, 1'b0, 1'b0},
    {3'd4, 24'h000000, 8'd200, 1'b0, 1'b0, 1'b1},
    {3'd5, 24'h123456, 8'd1,   1'b0, 1'b0, 1'b1},
    {3'd6, 24'hFEDCBA, 8'd50,  1'b1, 1'b0, 1'b0},
    {3'd7, 24'h000001, 8'd0,   1'b0, 1'b0, 1'b0},
    {3'd2, 24'h7FFFFF, 8'd10,  1'b0, 1'b0, 1'b1},
    {3'd3, 24'hFFFFFF, 8'd3,   1'b0, 1'b0, 1'b0}
  };

  function automatic longint gain_of(int k);
    if (k >= 255) return 0;
    return longint'($rtoi(8388608.0 * $pow(10.0, -0.375 * k / 20.0) + 0.5));
  endfunction

  function automatic logic [23:0] model_out(int k, logic signed [23:0] s, logic inv);
    longint p, r;
    p = longint'(s) * gain_of(k);
    r = (p + 64'sd4194304) >>> 23;
    if (inv) r = -r;
    if (r > 8388607) r = 8388607;
    return r[23:0];
  endfunction

  task automatic send(int ch, logic signed [23:0] s, string tag);
    int tgt;
    logic [23:0] exp_s;
    tgt = (master_mute || b_mute[ch]) ? 255 : int'(b_att[ch]);
    if (mcode[ch] < tgt) mcode[ch]++;
    else if (mcode[ch] > tgt) mcode[ch]--;
    exp_s = model_out(mcode[ch], s, invert);
    @(negedge clk);
    in_valid = 1'b1; in_chan = 3'(ch); in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
    total++;
    if (!out_valid || out_chan != 3'(ch) || out_sample != exp_s) begin
      bad++;
      $display("FAIL %s: ch %0d code %0d got valid=%0b chan=%0d sample=%h expected valid=1 chan=%0d sample=%h",
               tag, ch, mcode[ch], out_valid, out_chan, out_sample, ch, exp_s);
    end
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s: out_valid got %0b expected 0", tag, out_valid);
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin b_att[i] = 8'd0; mcode[i] = 0; end
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_chan !== 3'd0 || out_sample !== 24'd0) begin
      bad++;
      $display("FAIL R1 reset: got %0b/%0d/%h expected 0/0/000000", out_valid, out_chan, out_sample);
    end
    rst_n = 1'b1;
    idle_check("R3 idle after reset");

    // R1: unity gain at code 0 right after reset on every channel (R9 mapping)
    for (int c = 0; c < 8; c++) send(c, 24'sh2ABCDE, "R1 R9 code0 unity");

    // vector table: R2 R3 R7 R8 mixed patterns
    for (int i = 0; i < NV; i++) begin
      int ch;
      ch = int'(VEC[i][37:35]);
      b_att[ch] = VEC[i][10:3];
      b_mute[ch] = VEC[i][2];
      master_mute = VEC[i][1];
      invert = VEC[i][0];
      send(ch, VEC[i][34:11], "R2 R3 R8 vector");
    end
    idle_check("R3 no strobe");
    invert = 1'b0;
    b_mute = '0;

    // R2: full gain-law sweep on channel 7 up to silence
    b_att[7] = 8'd254;
    for (int n = 0; n < 258; n++) send(7, 24'sh5A5A5A, "R2 gain law sweep");
    b_mute[7] = 1'b1;
    send(7, 24'sh5A5A5A, "R2 code 255 silence");
    send(7, 24'sh5A5A5A, "R2 code 255 silence");
    b_mute[7] = 1'b0;

    // R4: ramp on channel 3 interleaved with channel 2, which holds
    b_att[3] = 8'd40;
    for (int n = 0; n < 45; n++) begin
      send(3, -24'sd3000000, "R4 ramp ch3");
      send(2, 24'sd1000000, "R4 other channel held");
    end

    // R5: individual mute fades out, unmute fades back
    b_att[5] = 8'd20;
    b_mute[5] = 1'b1;
    for (int n = 0; n < 260; n++) send(5, 24'sd7000000, "R5 mute fade");
    send(0, 24'sd7000000, "R5 R9 unmuted neighbour");
    b_mute[5] = 1'b0;
    for (int n = 0; n < 240; n++) send(5, 24'sd7000000, "R5 unmute fade");

    // R6: master mute overrides clear mute bits on all channels
    master_mute = 1'b1;
    for (int n = 0; n < 256; n++)
      for (int c = 0; c < 8; c += 3) send(c, -24'sd5000000, "R6 master fade");
    master_mute = 1'b0;
    for (int n = 0; n < 256; n++) send(0, 24'sd4000000, "R6 master release");

    // R7: saturation of negated full-scale negative at unity gain
    b_att[1] = 8'd0;
    for (int n = 0; n < 4; n++) send(1, 24'sd100, "R7 settle");
    invert = 1'b1;
    send(1, -24'sd8388608, "R7 invert saturation");
    send(1, 24'sd8388607, "R7 invert positive");
    invert = 1'b0;

    idle_check("R3 final idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule